// File: doc/BRIEF.md
# Memory-Mapped Terminal Registers

This block puts a byte-wide character terminal on a 32-bit word-addressed load/store bus. It has a receive side and a transmit side. The receive side takes bytes from an input stream such as a keyboard. The transmit side sends bytes to an output stream such as a display. Each side has a control word and a data word at fixed word addresses, so software can drive the terminal with plain loads and stores.

Software can poll the ready flag in a control word. It can also set that side's interrupt-enable flag and wait for the interrupt request. A load from the receive data word consumes the waiting byte. A store to the transmit data word starts sending one byte. The output stream uses a valid/ready handshake, and the transmit side becomes ready again once the sink accepts the byte. If a byte arrives before the previous one has been read, the receive side keeps the newer byte and records an overrun.

Top module: `term_mmio`

## Requirements
- R1: With `bus_sel` high, `bus_hit` is 1 only for the word-aligned addresses BASE+0x0 (receive control), BASE+0x4 (receive data), BASE+0x8 (transmit control) and BASE+0xC (transmit data), where BASE defaults to 0xFFFF0000. Any other address, including one with a nonzero bits 1:0, is not claimed and reads as 0.
- R2: Control word layout: bit 0 is the ready flag, bit 1 is interrupt enable, and bit 2 is overrun (receive side only). All other bits read 0. After reset the receive control word reads 0x0 and the transmit control word reads 0x1.
- R3: A cycle with `rx_valid` high stores `rx_byte` and sets the receive ready flag. The receive data word returns that byte in bits 7:0, with bits 31:8 at zero.
- R4: A load from the receive data word clears the receive ready flag, unless a new byte arrives in the same cycle.
- R5: A byte that arrives while receive ready is 1, and that is not in the same cycle as a receive data load, replaces the stored byte and sets overrun. A load from the receive control word clears overrun.
- R6: Only the interrupt-enable bit of a control word is writable. Store values in bit 0 and bit 2 have no effect.
- R7: A store to the transmit data word while transmit ready is 1 drives bits 7:0 onto `tx_byte`. It raises `tx_valid` from the next cycle on and clears transmit ready.
- R8: A store to the transmit data word while transmit ready is 0 is ignored, and the byte being sent is unchanged.
- R9: In the cycle after `tx_valid` and `tx_ready` are both high, `tx_valid` is 0 and transmit ready reads 1.
- R10: `irq` is 1 exactly when some side has both its interrupt-enable flag and its ready flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address of the word |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the same cycle |
| bus_hit | output | 1 | Address claimed by this block |
| rx_valid | input | 1 | Input stream presents a byte |
| rx_byte | input | 8 | Input stream byte |
| tx_valid | output | 1 | Output stream byte valid |
| tx_byte | output | 8 | Output stream byte |
| tx_ready | input | 1 | Output sink accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default base of 0xFFFF0000 and 8-bit data. This places the four registers at the top of the address space, so a neighbouring address below the window and an unaligned address inside it can both be shown to go unclaimed. The bench holds the output sink stalled under its own control. This makes it possible to store while the transmitter is busy, to enable interrupts mid-send, and to make two input bytes arrive back to back so that an overrun occurs.

// File: rtl/term_pkg.sv
package term_pkg;
  parameter int TERM_BUS_W  = 32;
  parameter int TERM_BYTE_W = 8;

  typedef enum logic [1:0] {
    SLOT_RX_CTL = 2'd0,
    SLOT_RX_DAT = 2'd1,
    SLOT_TX_CTL = 2'd2,
    SLOT_TX_DAT = 2'd3
  } slot_e;

  localparam int FLAG_RDY = 0;
  localparam int FLAG_IE  = 1;
  localparam int FLAG_OVR = 2;

  // Assemble a control word from its three flags.
  function automatic logic [TERM_BUS_W-1:0] pack_ctl(input logic rdy, input logic ie,
                                                      input logic ovr);
    logic [TERM_BUS_W-1:0] w;
    w = '0;
    w[FLAG_RDY] = rdy;
    w[FLAG_IE]  = ie;
    w[FLAG_OVR] = ovr;
    return w;
  endfunction
endpackage

// File: rtl/term_decode.sv
module term_decode
  import term_pkg::*;
#(
  parameter logic [TERM_BUS_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic                  sel,
  input  logic [TERM_BUS_W-1:0] addr,
  output logic                  hit,
  output slot_e                 slot,
  output logic [3:0]            strobe
);
  localparam int SLOTS = 4;

  function automatic logic in_window(input logic [TERM_BUS_W-1:0] a);
    return (a[TERM_BUS_W-1:4] == BASE[TERM_BUS_W-1:4]) && (a[1:0] == 2'b00);
  endfunction

  assign hit  = sel && in_window(addr);
  assign slot = slot_e'(addr[3:2]);

  for (genvar g = 0; g < SLOTS; g++) begin : g_strobe
    assign strobe[g] = hit && (addr[3:2] == g[1:0]);
  end
endmodule

// File: rtl/term_rx_side.sv
module term_rx_side
  import term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [TERM_BYTE_W-1:0] in_byte,
  input  logic                   rd_data,
  input  logic                   rd_ctl,
  input  logic                   wr_ctl,
  input  logic                   wr_ie,
  output logic                   rdy,
  output logic                   ie,
  output logic                   ovr,
  output logic [TERM_BYTE_W-1:0] byte_q
);
  logic lose_old;
  assign lose_old = in_valid && rdy && !rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy    <= 1'b0;
      ie     <= 1'b0;
      ovr    <= 1'b0;
      byte_q <= '0;
    end else begin
      if (in_valid) begin
        byte_q <= in_byte;
        rdy    <= 1'b1;
      end else if (rd_data) begin
        rdy <= 1'b0;
      end
      if (lose_old)    ovr <= 1'b1;
      else if (rd_ctl) ovr <= 1'b0;
      if (wr_ctl) ie <= wr_ie;
    end
  end
endmodule

// File: rtl/term_tx_side.sv
module term_tx_side
  import term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   store,
  input  logic [TERM_BYTE_W-1:0] store_byte,
  input  logic                   wr_ctl,
  input  logic                   wr_ie,
  input  logic                   sink_ready,
  output logic                   rdy,
  output logic                   ie,
  output logic                   out_valid,
  output logic [TERM_BYTE_W-1:0] out_byte,
  output logic                   accepted,
  output logic                   taken
);
  assign accepted = store && rdy;
  assign taken    = out_valid && sink_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy       <= 1'b1;
      ie        <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      if (taken) begin
        out_valid <= 1'b0;
        rdy       <= 1'b1;
      end else if (accepted) begin
        out_byte  <= store_byte;
        out_valid <= 1'b1;
        rdy       <= 1'b0;
      end
      if (wr_ctl) ie <= wr_ie;
    end
  end
endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import term_pkg::*;
#(
  parameter logic [TERM_BUS_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [TERM_BUS_W-1:0]  bus_addr,
  input  logic [TERM_BUS_W-1:0]  bus_wdata,
  output logic [TERM_BUS_W-1:0]  bus_rdata,
  output logic                   bus_hit,
  input  logic                   rx_valid,
  input  logic [TERM_BYTE_W-1:0] rx_byte,
  output logic                   tx_valid,
  output logic [TERM_BYTE_W-1:0] tx_byte,
  input  logic                   tx_ready,
  output logic                   irq
);
  localparam int PAD_W = TERM_BUS_W - TERM_BYTE_W;

  slot_e      slot;
  logic [3:0] strobe;

  // Named internal events, also seen by the bound checker.
  logic ev_rx_data_rd, ev_rx_ctl_rd, ev_rx_ctl_wr;
  logic ev_tx_ctl_wr, ev_tx_store, ev_tx_accept, ev_tx_done;
  logic rx_rdy, rx_ie, rx_ovr, tx_rdy, tx_ie;
  logic [TERM_BYTE_W-1:0] rx_q;

  term_decode #(.BASE(BASE)) u_dec (
    .sel(bus_sel), .addr(bus_addr), .hit(bus_hit), .slot(slot), .strobe(strobe)
  );

  assign ev_rx_ctl_rd  = strobe[SLOT_RX_CTL] && !bus_we;
  assign ev_rx_data_rd = strobe[SLOT_RX_DAT] && !bus_we;
  assign ev_rx_ctl_wr  = strobe[SLOT_RX_CTL] && bus_we;
  assign ev_tx_ctl_wr  = strobe[SLOT_TX_CTL] && bus_we;
  assign ev_tx_store   = strobe[SLOT_TX_DAT] && bus_we;

  term_rx_side u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_byte(rx_byte),
    .rd_data(ev_rx_data_rd), .rd_ctl(ev_rx_ctl_rd), .wr_ctl(ev_rx_ctl_wr),
    .wr_ie(bus_wdata[FLAG_IE]), .rdy(rx_rdy), .ie(rx_ie), .ovr(rx_ovr), .byte_q(rx_q)
  );

  term_tx_side u_tx (
    .clk(clk), .rst_n(rst_n), .store(ev_tx_store), .store_byte(bus_wdata[TERM_BYTE_W-1:0]),
    .wr_ctl(ev_tx_ctl_wr), .wr_ie(bus_wdata[FLAG_IE]), .sink_ready(tx_ready),
    .rdy(tx_rdy), .ie(tx_ie), .out_valid(tx_valid), .out_byte(tx_byte),
    .accepted(ev_tx_accept), .taken(ev_tx_done)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_hit && !bus_we) begin
      unique case (slot)
        SLOT_RX_CTL: bus_rdata = pack_ctl(rx_rdy, rx_ie, rx_ovr);
        SLOT_RX_DAT: bus_rdata = {{PAD_W{1'b0}}, rx_q};
        SLOT_TX_CTL: bus_rdata = pack_ctl(tx_rdy, tx_ie, 1'b0);
        SLOT_TX_DAT: bus_rdata = '0;
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign irq = (rx_ie && rx_rdy) || (tx_ie && tx_rdy);
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk
  import term_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_hit,
  input logic                   rx_valid,
  input logic                   tx_valid,
  input logic                   tx_ready,
  input logic [TERM_BYTE_W-1:0] tx_byte,
  input logic                   irq,
  input logic                   rx_rdy,
  input logic                   rx_ie,
  input logic                   rx_ovr,
  input logic                   tx_rdy,
  input logic                   tx_ie,
  input logic                   ev_rx_data_rd,
  input logic                   ev_rx_ctl_rd,
  input logic                   ev_tx_store
);
  a_r1_hit_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> bus_sel);
  a_r3_arrival_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_rdy);
  a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_data_rd && !rx_valid) |=> !rx_rdy);
  a_r5_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_rdy && !ev_rx_data_rd) |=> rx_ovr);
  a_r5_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ctl_rd && !rx_valid) |=> !rx_ovr);
  a_r7_store_starts_send: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_store && tx_rdy) |=> (tx_valid && !tx_rdy));
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_rdy);
  a_r8_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
  a_r9_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_rdy && !tx_valid));
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ie || tx_ie));
  a_r10_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_rdy || tx_rdy));
endmodule

bind term_mmio term_mmio_chk u_chk (.*);

// File: tb/term_mmio_tb.sv
`timescale 1ns/1ps
module term_mmio_tb;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [31:0] A_RXC = BASE + 32'h0;
  localparam logic [31:0] A_RXD = BASE + 32'h4;
  localparam logic [31:0] A_TXC = BASE + 32'h8;
  localparam logic [31:0] A_TXD = BASE + 32'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_hit;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid, tx_ready = 1'b0, irq;
  logic [7:0]  tx_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit m_tx_free = 1'b1;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  term_mmio #(.BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output logic h);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1; d = bus_rdata; h = bus_hit;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // Driver: the bench model decides whether the store will be taken.
  task automatic tx_send(input logic [7:0] b);
    if (m_tx_free) begin
      exp_q.push_back(b);
      m_tx_free = 1'b0;
    end
    bus_write(A_TXD, {24'h5A5A5A, b});
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Monitor: compares each handshaken byte against the scoreboard.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check("R8 unexpected byte", {24'h0, tx_byte}, 32'hFFFF_FFFF);
        else check("R7 sent byte", {24'h0, tx_byte}, {24'h0, exp_q.pop_front()});
        m_tx_free = 1'b1;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 irq after reset", {31'h0, irq}, 32'h0);
    check("R7 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
    bus_read(A_RXC, d, h); check("R2 rx ctl reset", d, 32'h0);
    check("R1 rx ctl claimed", {31'h0, h}, 32'h1);
    bus_read(A_TXC, d, h); check("R2 tx ctl reset", d, 32'h1);

    // R1: outside the window and unaligned are not claimed
    bus_read(BASE - 32'h4, d, h); check("R1 below window hit", {31'h0, h}, 32'h0);
    check("R1 below window data", d, 32'h0);
    bus_read(A_RXC + 32'h1, d, h); check("R1 unaligned hit", {31'h0, h}, 32'h0);
    bus_read(BASE + 32'h10, d, h); check("R1 above window hit", {31'h0, h}, 32'h0);

    // R6: ready and overrun bits are not writable
    bus_write(A_RXC, 32'h5); bus_read(A_RXC, d, h); check("R6 rx ready/ovr ignored", d, 32'h0);
    bus_write(A_TXC, 32'h4); bus_read(A_TXC, d, h); check("R6 tx ready kept", d, 32'h1);

    // R3/R4: receive one byte
    rx_push(8'hC3);
    bus_read(A_RXC, d, h); check("R3 rx ready set", d, 32'h1);
    bus_read(A_RXD, d, h); check("R3 rx data zero-extended", d, 32'h0000_00C3);
    bus_read(A_RXC, d, h); check("R4 rx ready cleared", d, 32'h0);

    // R5: overrun
    rx_push(8'h11); rx_push(8'h22);
    bus_read(A_RXC, d, h); check("R5 overrun set", d, 32'h5);
    bus_read(A_RXC, d, h); check("R5 overrun cleared by ctl read", d, 32'h1);
    bus_read(A_RXD, d, h); check("R5 newer byte kept", d, 32'h22);

    // R10: receive interrupt
    bus_write(A_RXC, 32'h3);
    bus_read(A_RXC, d, h); check("R6 rx ie written", d, 32'h2);
    check("R10 no irq without ready", {31'h0, irq}, 32'h0);
    rx_push(8'h7E); #1;
    check("R10 rx irq", {31'h0, irq}, 32'h1);
    bus_read(A_RXD, d, h); #1;
    check("R10 rx irq drops", {31'h0, irq}, 32'h0);
    bus_write(A_RXC, 32'h0);

    // R7: transmit with stalled sink
    tx_send(8'hA5); #1;
    check("R7 tx_valid", {31'h0, tx_valid}, 32'h1);
    check("R7 tx_byte", {24'h0, tx_byte}, 32'hA5);
    bus_read(A_TXC, d, h); check("R7 tx ready cleared", d, 32'h0);
    bus_write(A_TXC, 32'h2); #1;
    check("R10 no tx irq while busy", {31'h0, irq}, 32'h0);
    // R8: store while busy is ignored
    tx_send(8'h3C); #1;
    check("R8 byte unchanged", {24'h0, tx_byte}, 32'hA5);
    // R9: release the sink
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0; #1;
    check("R9 tx_valid dropped", {31'h0, tx_valid}, 32'h0);
    check("R10 tx irq", {31'h0, irq}, 32'h1);
    bus_read(A_TXC, d, h); check("R9 tx ready back", d, 32'h3);

    // Back-to-back sends through an always-ready sink
    bus_write(A_TXC, 32'h0);
    tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tx_send(8'h40 + 8'(i));
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    tx_ready = 1'b0;
    check("R7 scoreboard drained", exp_q.size(), 32'h0);
    summary();
  end
endmodule